// File: doc/BRIEF.md
# Frequency-Adjustable Nanosecond Time Counter

This block is the free-running time base of a network port. On every clock cycle, which stands for one 8 ns tick, a 40-bit nanosecond count moves forward by a fixed 8 ns. A signed correction, expressed in fractional nanoseconds, is added to or subtracted from a 32-bit sub-nanosecond residue on every tick. When the residue carries out, the step that tick becomes 9 ns. When it borrows, the step becomes 7 ns. Software trims the clock rate this way without ever touching the base step.

Software reaches the counter through a word-wide register port. The time is split across three words: residue, nanoseconds low and nanoseconds high. Reading the residue word freezes a copy of the nanosecond count, so that the following low and high reads belong to the same instant. Writes to the residue and low words are held in staging registers. The write of the high word then loads the whole value in a single cycle. A control word holds a stop bit, and the counter only runs while that bit is clear. The live count is also driven on a port for local consumers.

Top module: `ns_timebase`

## Requirements
- R1: After reset the count, the residue and the correction are zero, the control word reads 0x8000_0000, and the count does not move.
- R2: While running with a zero correction, `time_ns` grows by exactly 8 every cycle.
- R3: When bit 31 of the correction word (address 3) is clear, bits 30:0 are added to the residue each tick. A carry out of bit 31 of the residue makes that tick's step 9 ns.
- R4: When bit 31 of the correction word is set, bits 30:0 are subtracted from the residue modulo 2^32. A borrow makes that tick's step 7 ns. A negative zero leaves the residue unchanged.
- R5: Register map: 0 residue, 1 ns low, 2 ns high, 3 correction, 4 control. The correction word reads back all 32 bits. Any unmapped address reads zero. Read data appears on `reg_rdata` in the cycle after the read strobe.
- R6: Bit 31 of the control word (address 4) stops the counter when it is 1. Writing 0 starts counting. The other control bits read as zero.
- R7: A read of address 0 returns the live residue and freezes the nanosecond count of that cycle. Later reads of addresses 1 and 2 return the frozen value while the counter keeps running.
- R8: A read of address 2 releases the frozen copy. After that, address 1 returns the live count again.
- R9: Address 2 returns count bits 39:32 in bits 7:0, and bits 31:8 read as zero.
- R10: Writes to address 0 and address 1 leave the running count unchanged. A write to address 2 loads {wdata[7:0], staged low} and the staged residue, and `time_ns` shows the new value on the next cycle.
- R11: The count wraps modulo 2^40, so 0xFF_FFFF_FFFC becomes 0x00_0000_0004 after one tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Tick clock, one 8 ns tick per cycle |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 3 | Register word address |
| reg_wr | input | 1 | Write strobe, one cycle |
| reg_rd | input | 1 | Read strobe, one cycle |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| time_ns | output | 40 | Live nanosecond count |

## Verification
A residue update with the wrong direction or the wrong carry handling shows up as a count that drifts by 1 ns, beginning at the first tick whose carry or borrow differs. The tabled rate cases are chosen so that this drift appears within one to four ticks. A snapshot that is not held, or not released, shows up in the very next low or high read as a value that differs from the count sampled at the latching read. A commit that leaks out early shows up on `time_ns` one cycle after the staging write. A step outside 7 to 9 ns, or any movement while stopped, is flagged in the cycle after it happens.

// File: rtl/ns_timebase_pkg.sv
package ns_timebase_pkg;
  localparam logic [2:0] RA_RESID = 3'd0;
  localparam logic [2:0] RA_NS_LO = 3'd1;
  localparam logic [2:0] RA_NS_HI = 3'd2;
  localparam logic [2:0] RA_RATE  = 3'd3;
  localparam logic [2:0] RA_AUX   = 3'd4;
  localparam int STOP_BIT = 31;
  localparam int SIGN_BIT = 31;
endpackage

// File: rtl/ns_tb_step.sv
module ns_tb_step #(
  parameter int NS_W    = 40,
  parameter int FRAC_W  = 32,
  parameter int MAG_W   = 31,
  parameter int STEP_NS = 8
) (
  input  logic [NS_W-1:0]   ns_cur,
  input  logic [FRAC_W-1:0] frac_cur,
  input  logic [MAG_W-1:0]  mag,
  input  logic              neg,
  output logic [NS_W-1:0]   ns_nxt,
  output logic [FRAC_W-1:0] frac_nxt
);
  localparam int PAD_W = FRAC_W + 1 - MAG_W;

  logic [FRAC_W:0] wide;
  logic            spill;

  always_comb begin
    if (neg) wide = {1'b0, frac_cur} - {{PAD_W{1'b0}}, mag};
    else     wide = {1'b0, frac_cur} + {{PAD_W{1'b0}}, mag};
    spill    = wide[FRAC_W];
    frac_nxt = wide[FRAC_W-1:0];
    if (neg) ns_nxt = ns_cur + NS_W'(STEP_NS) - NS_W'(spill);
    else     ns_nxt = ns_cur + NS_W'(STEP_NS) + NS_W'(spill);
  end
endmodule

// File: rtl/ns_tb_state.sv
module ns_tb_state #(
  parameter int NS_W   = 40,
  parameter int FRAC_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic              load,
  input  logic [NS_W-1:0]   load_ns,
  input  logic [FRAC_W-1:0] load_frac,
  input  logic [NS_W-1:0]   ns_nxt,
  input  logic [FRAC_W-1:0] frac_nxt,
  output logic [NS_W-1:0]   ns_q,
  output logic [FRAC_W-1:0] frac_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ns_q   <= '0;
      frac_q <= '0;
    end else if (load) begin
      ns_q   <= load_ns;
      frac_q <= load_frac;
    end else if (run) begin
      ns_q   <= ns_nxt;
      frac_q <= frac_nxt;
    end
  end
endmodule

// File: rtl/ns_tb_snap.sv
module ns_tb_snap #(
  parameter int NS_W = 40
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            capture,
  input  logic            release_snap,
  input  logic [NS_W-1:0] live_ns,
  output logic            held,
  output logic [NS_W-1:0] snap_ns
);
  always_ff @(posedge clk) begin
    if (rst) begin
      held    <= 1'b0;
      snap_ns <= '0;
    end else if (capture) begin
      held    <= 1'b1;
      snap_ns <= live_ns;
    end else if (release_snap) begin
      held    <= 1'b0;
    end
  end
endmodule

// File: rtl/ns_tb_regs.sv
module ns_tb_regs
  import ns_timebase_pkg::*;
#(
  parameter int NS_W   = 40,
  parameter int FRAC_W = 32,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic              rd,
  input  logic [DATA_W-1:0] wdata,
  input  logic [NS_W-1:0]   live_ns,
  input  logic [FRAC_W-1:0] live_frac,
  input  logic              snap_held,
  input  logic [NS_W-1:0]   snap_ns,
  output logic [DATA_W-2:0] rate_mag,
  output logic              rate_neg,
  output logic              run,
  output logic              commit,
  output logic [NS_W-1:0]   commit_ns,
  output logic [FRAC_W-1:0] commit_frac,
  output logic              capture,
  output logic              release_snap,
  output logic [DATA_W-1:0] rdata
);
  localparam int HI_W = NS_W - DATA_W;

  logic              stop_q;
  logic [DATA_W-1:0] stage_lo;
  logic [FRAC_W-1:0] stage_frac;
  logic [NS_W-1:0]   ns_view;
  logic [DATA_W-1:0] rd_val;

  wire sel_resid = (addr == ADDR_W'(RA_RESID));
  wire sel_lo    = (addr == ADDR_W'(RA_NS_LO));
  wire sel_hi    = (addr == ADDR_W'(RA_NS_HI));
  wire sel_rate  = (addr == ADDR_W'(RA_RATE));
  wire sel_aux   = (addr == ADDR_W'(RA_AUX));

  assign run          = ~stop_q;
  assign commit       = wr & sel_hi;
  assign commit_ns    = {wdata[HI_W-1:0], stage_lo};
  assign commit_frac  = stage_frac;
  assign capture      = rd & sel_resid;
  assign release_snap = rd & sel_hi;

  always_ff @(posedge clk) begin
    if (rst) begin
      stop_q     <= 1'b1;
      rate_mag   <= '0;
      rate_neg   <= 1'b0;
      stage_lo   <= '0;
      stage_frac <= '0;
    end else if (wr) begin
      if (sel_aux)   stop_q <= wdata[STOP_BIT];
      if (sel_rate) begin
        rate_mag <= wdata[DATA_W-2:0];
        rate_neg <= wdata[SIGN_BIT];
      end
      if (sel_lo)    stage_lo   <= wdata;
      if (sel_resid) stage_frac <= FRAC_W'(wdata);
    end
  end

  always_comb begin
    ns_view = snap_held ? snap_ns : live_ns;
    rd_val  = '0;
    if (sel_resid)     rd_val = DATA_W'(live_frac);
    else if (sel_lo)   rd_val = ns_view[DATA_W-1:0];
    else if (sel_hi)   rd_val = {{(DATA_W-HI_W){1'b0}}, ns_view[NS_W-1:DATA_W]};
    else if (sel_rate) rd_val = {rate_neg, rate_mag};
    else if (sel_aux)  rd_val = {stop_q, {(DATA_W-1){1'b0}}};
  end

  always_ff @(posedge clk) begin
    if (rst)     rdata <= '0;
    else if (rd) rdata <= rd_val;
  end
endmodule

// File: rtl/ns_timebase.sv
module ns_timebase #(
  parameter int NS_W    = 40,
  parameter int FRAC_W  = 32,
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 3,
  parameter int STEP_NS = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic [NS_W-1:0]   time_ns
);
  localparam int MAG_W = DATA_W - 1;

  logic [NS_W-1:0]   ns_q, ns_nxt, commit_ns, snap_ns;
  logic [FRAC_W-1:0] frac_q, frac_nxt, commit_frac;
  logic [MAG_W-1:0]  rate_mag;
  logic              rate_neg, run_en, commit, capture, release_snap, snap_held;

  ns_tb_step #(.NS_W(NS_W), .FRAC_W(FRAC_W), .MAG_W(MAG_W), .STEP_NS(STEP_NS)) u_step (
    .ns_cur(ns_q), .frac_cur(frac_q), .mag(rate_mag), .neg(rate_neg),
    .ns_nxt(ns_nxt), .frac_nxt(frac_nxt)
  );

  ns_tb_state #(.NS_W(NS_W), .FRAC_W(FRAC_W)) u_state (
    .clk(clk), .rst(rst), .run(run_en), .load(commit),
    .load_ns(commit_ns), .load_frac(commit_frac),
    .ns_nxt(ns_nxt), .frac_nxt(frac_nxt), .ns_q(ns_q), .frac_q(frac_q)
  );

  ns_tb_snap #(.NS_W(NS_W)) u_snap (
    .clk(clk), .rst(rst), .capture(capture), .release_snap(release_snap),
    .live_ns(ns_q), .held(snap_held), .snap_ns(snap_ns)
  );

  ns_tb_regs #(.NS_W(NS_W), .FRAC_W(FRAC_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst(rst), .addr(reg_addr), .wr(reg_wr), .rd(reg_rd), .wdata(reg_wdata),
    .live_ns(ns_q), .live_frac(frac_q), .snap_held(snap_held), .snap_ns(snap_ns),
    .rate_mag(rate_mag), .rate_neg(rate_neg), .run(run_en), .commit(commit),
    .commit_ns(commit_ns), .commit_frac(commit_frac), .capture(capture),
    .release_snap(release_snap), .rdata(reg_rdata)
  );

  assign time_ns = ns_q;
endmodule

// File: rtl/ns_timebase_chk.sv
module ns_timebase_chk
  import ns_timebase_pkg::*;
#(
  parameter int NS_W   = 40,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 3
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] reg_addr,
  input logic              reg_wr,
  input logic              reg_rd,
  input logic [DATA_W-1:0] reg_wdata,
  input logic [DATA_W-1:0] reg_rdata,
  input logic [NS_W-1:0]   time_ns,
  input logic              run_en,
  input logic              commit
);
  localparam int HI_W = NS_W - DATA_W;

  logic rst_q;
  always_ff @(posedge clk) rst_q <= rst;

  // R1
  always @(negedge clk) begin
    if (rst_q) reset_clear_chk: assert (time_ns == '0);
  end

  // R2 R3 R4 R11
  step_size_chk: assert property (@(posedge clk) disable iff (rst)
    (run_en && !commit) |=>
      ((time_ns - $past(time_ns)) inside {NS_W'(7), NS_W'(8), NS_W'(9)}));

  // R6
  stopped_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!run_en && !commit) |=> $stable(time_ns));

  // R10
  commit_hi_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_addr == ADDR_W'(RA_NS_HI)) |=>
      (time_ns[NS_W-1:DATA_W] == $past(reg_wdata[HI_W-1:0])));

  // R9
  high_rsvd_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_rd && reg_addr == ADDR_W'(RA_NS_HI)) |=> (reg_rdata[DATA_W-1:HI_W] == '0));
endmodule

bind ns_timebase ns_timebase_chk #(.NS_W(NS_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
  .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .time_ns(time_ns),
  .run_en(run_en), .commit(commit)
);

// File: tb/ns_timebase_test.sv
module ns_timebase_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  reg_addr = '0;
  logic        reg_wr = 1'b0;
  logic        reg_rd = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [39:0] time_ns;

  int nchk = 0;
  int nerr = 0;
  bit done = 1'b0;
  logic [39:0] live_at;

  always #5 clk = ~clk;

  ns_timebase uut (
    .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .time_ns(time_ns)
  );

  typedef struct packed {
    logic [31:0] rate;
    logic [31:0] frac0;
    logic [7:0]  n;
    logic [31:0] exp_lo;
    logic [31:0] exp_fr;
  } vec_t;

  // start count 1000, n ticks, then stop
  localparam vec_t VECS [6] = '{
    '{32'h0000_0000, 32'h0000_0000, 8'd5, 32'd1040, 32'h0000_0000},
    '{32'h4000_0000, 32'h0000_0000, 8'd4, 32'd1033, 32'h0000_0000},
    '{32'hC000_0000, 32'h0000_0000, 8'd3, 32'd1023, 32'h4000_0000},
    '{32'h7FFF_FFFF, 32'h0000_0001, 8'd3, 32'd1025, 32'h7FFF_FFFE},
    '{32'h8000_0001, 32'h0000_0000, 8'd2, 32'd1015, 32'hFFFF_FFFE},
    '{32'h8000_0000, 32'h0000_0005, 8'd2, 32'd1016, 32'h0000_0005}
  };

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    reg_addr = a; reg_rd = 1'b1; live_at = time_ns;
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nchk++; nerr++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic [39:0] snap, v;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    check("R1 count", 64'(time_ns), 64'd0);
    rd(3'd3, d); check("R1 rate", 64'(d), 64'h0);
    rd(3'd4, d); check("R1 aux", 64'(d), 64'h8000_0000);
    rd(3'd0, d); check("R1 residue", 64'(d), 64'h0);
    rd(3'd2, d); check("R1 high", 64'(d), 64'h0);
    repeat (4) @(negedge clk);
    check("R1 stopped", 64'(time_ns), 64'd0);

    // R3 R4 rate vectors
    for (int i = 0; i < 6; i++) begin
      wr(3'd4, 32'h8000_0000);
      wr(3'd0, VECS[i].frac0);
      wr(3'd1, 32'd1000);
      wr(3'd2, 32'd0);
      wr(3'd3, VECS[i].rate);
      wr(3'd4, 32'd0);
      repeat (int'(VECS[i].n) - 1) @(negedge clk);
      wr(3'd4, 32'h8000_0000);
      rd(3'd0, d); check($sformatf("R3/R4 vec%0d residue", i), 64'(d), 64'(VECS[i].exp_fr));
      rd(3'd1, d); check($sformatf("R3/R4 vec%0d ns", i), 64'(d), 64'(VECS[i].exp_lo));
      rd(3'd2, d);
    end

    // R5 readback and unmapped
    wr(3'd3, 32'h8000_0001);
    rd(3'd3, d); check("R5 rate readback", 64'(d), 64'h8000_0001);
    rd(3'd7, d); check("R5 unmapped", 64'(d), 64'h0);

    // R2 plain stepping across the 32-bit boundary
    wr(3'd3, 32'h0);
    wr(3'd0, 32'h0);
    wr(3'd1, 32'hFFFF_FFF0);
    wr(3'd2, 32'h05);
    wr(3'd4, 32'h0);
    check("R2 start", 64'(time_ns), 64'h05_FFFF_FFF0);
    repeat (3) @(negedge clk);
    check("R2 step", 64'(time_ns), 64'h06_0000_0008);

    // R7 snapshot freeze
    rd(3'd0, d);
    snap = live_at;
    check("R7 residue", 64'(d), 64'h0);
    repeat (3) @(negedge clk);
    rd(3'd1, d); check("R7 low frozen", 64'(d), 64'(snap[31:0]));
    rd(3'd2, d); check("R7 high frozen", 64'(d), 64'(snap[39:32]));
    // R8 released
    rd(3'd1, d); check("R8 low live", 64'(d), 64'(live_at[31:0]));

    // R10 staging
    wr(3'd4, 32'h8000_0000);
    v = time_ns;
    wr(3'd1, 32'h0000_1234);
    check("R10 low staged", 64'(time_ns), 64'(v));
    wr(3'd0, 32'h0000_0077);
    check("R10 residue staged", 64'(time_ns), 64'(v));
    wr(3'd2, 32'hABCD_EF12);
    check("R10 commit", 64'(time_ns), 64'h12_0000_1234);
    rd(3'd0, d); check("R10 residue committed", 64'(d), 64'h77);
    // R9 reserved high bits
    rd(3'd2, d); check("R9 high word", 64'(d), 64'h12);

    // R6 control word
    wr(3'd4, 32'hFFFF_FFFF);
    rd(3'd4, d); check("R6 aux readback", 64'(d), 64'h8000_0000);
    v = time_ns;
    repeat (4) @(negedge clk);
    check("R6 stopped", 64'(time_ns), 64'(v));
    wr(3'd4, 32'h7FFF_FFFF);
    rd(3'd4, d); check("R6 aux run", 64'(d), 64'h0);
    check("R6 running", 64'(time_ns != v), 64'd1);

    // R11 wrap
    wr(3'd4, 32'h8000_0000);
    wr(3'd1, 32'hFFFF_FFFC);
    wr(3'd2, 32'h0000_00FF);
    check("R11 preset", 64'(time_ns), 64'hFF_FFFF_FFFC);
    wr(3'd4, 32'h0);
    check("R11 before tick", 64'(time_ns), 64'hFF_FFFF_FFFC);
    @(negedge clk);
    check("R11 wrapped", 64'(time_ns), 64'h4);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule